// File: doc/BRIEF.md
# Receiver Power Mode Sequencer

This block decides which operating mode a sub-GHz receiver is in and when its receive chain, demodulated-data output and system-clock output may run. It watches three inputs: an internal supply-good level, an active-high reset request pin and a standby request pin. From these it steps the device between off, a four-phase boot, receive, standby, a wake-up interval and a held reset. A single mode-status output is low only while the receiver is fully receiving.

Every delay is a parameter counted in reference-clock cycles. The defaults assume a 30 MHz reference: a 1 ms supply ramp phase, 10 ms configuration load, 8.5 ms settle and 3 ms calibration, a 0.5 ms wake-up from standby and a 10 ms minimum supply-low interval. A bench can shrink them all. The external pins pass through two-flop synchronisers. The standby pin is also debounced, so that noise coupled onto its trace does not flip the mode.

Top module: `rx_power_seq`

## Requirements
- R1: mode_stat_o is 0 only in the receive state and 1 in every other state (off, boot, standby, wake, reset). Whenever it is 0, rx_en_o, dout_en_o and clk_out_en_o are all 1.
- R2: A rising supply-good is accepted only if the synchronised supply-good was low for at least OFF_MIN_CYC cycles just before. Otherwise the block stays off until the supply drops again for a full qualifying interval.
- R3: An accepted power-on runs the boot phases ramp, load, settle and calibrate for P_RAMP_CYC, P_LOAD_CYC, P_SETL_CYC and P_CAL_CYC cycles, in that order. mode_stat_o falls 3 + their sum cycles after pwr_good_i rises. Loss of supply-good in any state returns the block to off.
- R4: rx_en_o is 1 in the calibrate phase, in wake and in receive. dout_en_o and clk_out_en_o are 1 only in receive, so both are 0 in off, boot, standby, wake and reset.
- R5: The standby pin is synchronised and then accepted only after DEB_CYC consecutive cycles at its new level. A pulse shorter than that changes nothing.
- R6: From receive, asserting stby_req_i raises mode_stat_o 3 + DEB_CYC cycles later. Releasing it in standby passes through a wake interval of WAKE_CYC cycles, with no boot, and mode_stat_o falls 3 + DEB_CYC + WAKE_CYC cycles after the release.
- R7: A standby request seen during any boot phase is latched and acted on when boot finishes. The block then enters standby for at least one cycle, and if the request has since been withdrawn it proceeds through wake to receive.
- R8: With supply present, a synchronised reset request forces the reset state from any state and overrides standby. The block holds reset while the pin stays high. On release it reboots from the load phase, skipping the ramp phase, and mode_stat_o falls 3 + P_LOAD_CYC + P_SETL_CYC + P_CAL_CYC cycles after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the logic |
| pwr_good_i | input | 1 | Supply-good level, asynchronous |
| rst_req_i | input | 1 | Active-high device reset request pin, asynchronous |
| stby_req_i | input | 1 | Standby request pin (1 = standby), asynchronous |
| mode_stat_o | output | 1 | Mode status: 0 in receive, 1 otherwise |
| rx_en_o | output | 1 | Receive chain enable |
| dout_en_o | output | 1 | Demodulated data output enable |
| clk_out_en_o | output | 1 | System clock output enable |

## Verification
The assertions assume that the three pins are asynchronous levels sampled only through the synchronisers. They also assume that a supply loss or a reset request can arrive in any cycle, so they speak only of states one cycle after the synchronised value. The stimulus changes every pin on the falling clock edge and holds each level for whole cycles. Each supply drop is either clearly shorter or clearly longer than the qualifying interval once the synchroniser delay is counted, and standby pulses are either a few cycles short of the debounce count or long enough to be accepted.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [3:0] {
    ST_OFF   = 4'd0,
    ST_RAMP  = 4'd1,
    ST_LOAD  = 4'd2,
    ST_SETL  = 4'd3,
    ST_CAL   = 4'd4,
    ST_RX    = 4'd5,
    ST_STBY  = 4'd6,
    ST_WAKE  = 4'd7,
    ST_RST   = 4'd8
  } pwr_state_e;

  function automatic logic is_boot(pwr_state_e s);
    return (s == ST_RAMP) || (s == ST_LOAD) || (s == ST_SETL) || (s == ST_CAL);
  endfunction
endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) ff_q[s] <= '0;
    end else begin
      ff_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rps_debounce.sv
module rps_debounce #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = $clog2(CYC > 1 ? CYC : 2);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (lvl_i != out_q) begin
      if (cnt_q == LAST) begin
        out_q <= lvl_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign lvl_o = out_q;

  // new level must equal the input that was being qualified
  assert_deb_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> ($past(lvl_i) == out_q));
endmodule

// File: rtl/rps_low_timer.sv
module rps_low_timer #(
  parameter int LIMIT = 300000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  output logic ok_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (pwr_i)       cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == LIM);

  assert_low_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> !$past(pwr_i));
endmodule

// File: rtl/rps_dwell.sv
module rps_dwell #(
  parameter int CW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_dwell_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/rx_power_seq.sv
module rx_power_seq
  import rps_pkg::*;
#(
  parameter int P_RAMP_CYC  = 30000,
  parameter int P_LOAD_CYC  = 300000,
  parameter int P_SETL_CYC  = 255000,
  parameter int P_CAL_CYC   = 90000,
  parameter int WAKE_CYC    = 15000,
  parameter int OFF_MIN_CYC = 300000,
  parameter int DEB_CYC     = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic rst_req_i,
  input  logic stby_req_i,
  output logic mode_stat_o,
  output logic rx_en_o,
  output logic dout_en_o,
  output logic clk_out_en_o
);
  localparam int MAX_A  = (P_RAMP_CYC > P_LOAD_CYC) ? P_RAMP_CYC : P_LOAD_CYC;
  localparam int MAX_B  = (P_SETL_CYC > P_CAL_CYC) ? P_SETL_CYC : P_CAL_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D  = (MAX_C > WAKE_CYC) ? MAX_C : WAKE_CYC;
  localparam int CNT_W  = $clog2(MAX_D + 1);
  localparam logic [CNT_W-1:0] RAMP_LD = CNT_W'(P_RAMP_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_LD = CNT_W'(P_LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] SETL_LD = CNT_W'(P_SETL_CYC - 1);
  localparam logic [CNT_W-1:0] CAL_LD  = CNT_W'(P_CAL_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 1);

  logic [2:0] pin_s;
  logic       pwr_s, rst_s, stby_s, stby_q;
  logic       low_ok, dwell_done, dwell_load;
  logic [CNT_W-1:0] dwell_val;
  pwr_state_e state_q, state_d;
  logic       pend_q, pend_d;

  rps_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stby_req_i, rst_req_i, pwr_good_i}),
    .q_o   (pin_s)
  );
  assign pwr_s  = pin_s[0];
  assign rst_s  = pin_s[1];
  assign stby_s = pin_s[2];

  rps_debounce #(.CYC(DEB_CYC)) i_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (stby_s),
    .lvl_o (stby_q)
  );

  rps_low_timer #(.LIMIT(OFF_MIN_CYC)) i_low (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwr_i (pwr_s),
    .ok_o  (low_ok)
  );

  rps_dwell #(.CW(CNT_W)) i_dwell (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(dwell_load),
    .val_i (dwell_val),
    .done_o(dwell_done)
  );

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (!pwr_s) begin
      state_d = ST_OFF;
      pend_d  = 1'b0;
    end else if (rst_s && state_q != ST_OFF) begin
      state_d = ST_RST;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF:  if (low_ok) state_d = ST_RAMP;
        ST_RAMP: begin
          if (stby_q) pend_d = 1'b1;
          if (dwell_done) state_d = ST_LOAD;
        end
        ST_LOAD: begin
          if (stby_q) pend_d = 1'b1;
          if (dwell_done) state_d = ST_SETL;
        end
        ST_SETL: begin
          if (stby_q) pend_d = 1'b1;
          if (dwell_done) state_d = ST_CAL;
        end
        ST_CAL: begin
          if (stby_q) pend_d = 1'b1;
          if (dwell_done) begin
            state_d = (pend_q || stby_q) ? ST_STBY : ST_RX;
            pend_d  = 1'b0;
          end
        end
        ST_RX:   if (stby_q) state_d = ST_STBY;
        ST_STBY: if (!stby_q) state_d = ST_WAKE;
        ST_WAKE: begin
          if (stby_q)          state_d = ST_STBY;
          else if (dwell_done) state_d = ST_RX;
        end
        ST_RST:  state_d = ST_LOAD;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_comb begin
    dwell_load = (state_d != state_q);
    unique case (state_d)
      ST_RAMP: dwell_val = RAMP_LD;
      ST_LOAD: dwell_val = LOAD_LD;
      ST_SETL: dwell_val = SETL_LD;
      ST_CAL:  dwell_val = CAL_LD;
      ST_WAKE: dwell_val = WAKE_LD;
      default: dwell_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign mode_stat_o  = (state_q != ST_RX);
  assign rx_en_o      = (state_q == ST_RX) || (state_q == ST_WAKE) || (state_q == ST_CAL);
  assign dout_en_o    = (state_q == ST_RX);
  assign clk_out_en_o = (state_q == ST_RX);

  assert_rx_outputs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_stat_o |-> (rx_en_o && dout_en_o && clk_out_en_o));

  assert_qualify_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && !low_ok) |=> state_q != ST_RAMP);

  assert_supply_loss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_s |=> state_q == ST_OFF);

  assert_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY || state_q == ST_RST || state_q == ST_OFF) |-> (!dout_en_o && !clk_out_en_o));

  assert_stby_no_boot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STBY && pwr_s && !rst_s) |=> (state_q == ST_STBY || state_q == ST_WAKE));

  assert_boot_no_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CAL && pend_q) |=> state_q != ST_RX);

  assert_rst_prio_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_s && pwr_s && state_q != ST_OFF) |=> state_q == ST_RST);
endmodule

// File: tb/test_rx_power_seq.sv
module test_rx_power_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int RAMP = 5, LOAD = 20, SETL = 17, CAL = 6;
  localparam int WAKE = 10, OFFMIN = 30, DEB = 4;
  localparam int T_BOOT  = 3 + RAMP + LOAD + SETL + CAL;   // 51
  localparam int T_REBOOT = 3 + LOAD + SETL + CAL;         // 46
  localparam int T_CAL   = 3 + RAMP + LOAD + SETL;         // 45
  localparam int T_STBY  = 3 + DEB;                        // 7
  localparam int T_WAKE  = 3 + DEB + WAKE;                 // 17

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr = 1'b0, rreq = 1'b0, sreq = 1'b0;
  logic mode_stat, rx_en, dout_en, clk_en;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_power_seq #(
    .P_RAMP_CYC(RAMP), .P_LOAD_CYC(LOAD), .P_SETL_CYC(SETL), .P_CAL_CYC(CAL),
    .WAKE_CYC(WAKE), .OFF_MIN_CYC(OFFMIN), .DEB_CYC(DEB), .SYNC_STAGES(2)
  ) i_rx_power_seq (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr), .rst_req_i(rreq), .stby_req_i(sreq),
    .mode_stat_o(mode_stat), .rx_en_o(rx_en), .dout_en_o(dout_en), .clk_out_en_o(clk_en)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts falling edges until mode_stat_o drops
  task automatic time_to_rx(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mode_stat && n < lim);
  endtask

  task automatic t_reset_state;
    cycles(2);
    chk(mode_stat == 1'b1, "R1 reset mode_stat", mode_stat, 1);
    chk({rx_en, dout_en, clk_en} == 3'b000, "R4 reset enables", {rx_en, dout_en, clk_en}, 0);
  endtask

  task automatic t_power_on;
    int n = 0, first_rx = -1;
    cycles(OFFMIN + 10);
    pwr = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (rx_en && first_rx < 0) first_rx = n;
      if (n == 20) chk(dout_en == 1'b0 && mode_stat, "R4 boot outputs off", dout_en, 0);
    end while (mode_stat && n < 200);
    chk(n == T_BOOT, "R3 boot duration", n, T_BOOT);
    chk(first_rx == T_CAL, "R4 rx_en in calibrate", first_rx, T_CAL);
    chk(dout_en && clk_en && rx_en, "R1 receive enables", {rx_en, dout_en, clk_en}, 7);
  endtask

  task automatic t_standby_cycle;
    int n = 0;
    sreq = 1'b1;
    time_to_rx(0, n);
    do begin
      @(negedge clk);
      n++;
    end while (!mode_stat && n < 50);
    chk(n == T_STBY, "R6 standby entry", n, T_STBY);
    chk(!clk_en && !dout_en && !rx_en, "R4 standby enables", {rx_en, dout_en, clk_en}, 0);
    cycles(5);
    sreq = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 10) chk(rx_en && mode_stat && !clk_en, "R4 wake enables", {rx_en, dout_en, clk_en}, 4);
    end while (mode_stat && n < 100);
    chk(n == T_WAKE, "R6 wake duration", n, T_WAKE);
  endtask

  task automatic t_glitch;
    int hi = 0;
    sreq = 1'b1;
    cycles(DEB - 2);
    sreq = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mode_stat) hi++;
    end
    chk(hi == 0, "R5 short standby pulse ignored", hi, 0);
  endtask

  task automatic t_reset_from_rx;
    int n = 0;
    rreq = 1'b1;
    cycles(8);
    chk(mode_stat && !dout_en && !clk_en && !rx_en, "R8 reset state outputs", {mode_stat, rx_en, dout_en, clk_en}, 8);
    cycles(2);
    rreq = 1'b0;
    time_to_rx(200, n);
    chk(n == T_REBOOT, "R8 reboot duration", n, T_REBOOT);
  endtask

  task automatic t_short_drop;
    int bad = 0, n = 0;
    pwr = 1'b0;
    cycles(5);
    chk(mode_stat && !clk_en, "R3 supply loss to off", mode_stat, 1);
    cycles(5);
    pwr = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!mode_stat || rx_en) bad++;
    end
    chk(bad == 0, "R2 short low rejected", bad, 0);
    pwr = 1'b0;
    cycles(OFFMIN + 10);
    pwr = 1'b1;
    time_to_rx(200, n);
    chk(n == T_BOOT, "R2 qualified power-on", n, T_BOOT);
  endtask

  task automatic t_boot_latch;
    int n = 0;
    pwr = 1'b0;
    cycles(OFFMIN + 10);
    pwr = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (n == 15) sreq = 1'b1;
      if (n == 25) sreq = 1'b0;
    end while (mode_stat && n < 200);
    chk(n == T_BOOT + 1 + WAKE, "R7 latched standby at boot end", n, T_BOOT + 1 + WAKE);
  endtask

  task automatic t_boot_hold_and_reset;
    int n = 0;
    pwr = 1'b0;
    cycles(OFFMIN + 10);
    sreq = 1'b1;
    pwr = 1'b1;
    cycles(T_BOOT + 9);
    chk(mode_stat && !rx_en && !clk_en, "R7 held request ends in standby", {mode_stat, rx_en}, 2);
    rreq = 1'b1;
    cycles(10);
    rreq = 1'b0;
    cycles(T_REBOOT - 4);
    chk(rx_en == 1'b1, "R8 reset overrides standby", rx_en, 1);
    cycles(8);
    chk(mode_stat && !rx_en, "R8 standby after reboot", {mode_stat, rx_en}, 2);
    sreq = 1'b0;
    time_to_rx(100, n);
    chk(n == T_WAKE, "R6 release from standby", n, T_WAKE);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    t_reset_state();
    t_power_on();
    t_standby_cycle();
    t_glitch();
    t_reset_from_rx();
    t_short_drop();
    t_boot_latch();
    t_boot_hold_and_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule